// File: doc/BRIEF.md
# Panel Control Register Write Sequencer

This block turns one request into a complete write of a 16-bit value to an 8-bit-addressed control register of a display panel. A display panel of this kind takes its commands over a three-wire serial link. A write is carried as two separate 24-bit serial frames, each framed by its own low pulse of the chip select. The first frame is the index frame: a selector byte of 0x74, a zero byte, and then the register address. It points the panel at a register. The second frame is the data frame: a prefix byte of 0x76, the high byte of the value, and then the low byte. The panel stores that value in the register the index frame selected.

The serial link runs in SPI mode 3. The clock idles high, and data is launched on each falling edge so that the panel samples it on the rising edge. The serial clock is made from the system clock by a half-period divider. The default setting gives 250 MHz / 14, about 17.9 MHz, which keeps the serial clock under the 20 MHz limit. The panel's receive line is not used.

The block is used with a one-cycle start strobe and the address and value placed beside it. Typical writes are the shutdown register 0x11 (bit 0 set shuts the panel down; bit 0 clear turns it on) and the driver output register 0x01 (base bits 0x2AEF, with bits 8, 9, 11 and 13 chosen by the user). The block raises busy for the whole transaction and gives a one-cycle done pulse when the second frame has been released.

Top module: `panel_spi_writer`

## Requirements
- R1: The first frame of a write is 24 bits, sent most significant bit first: 0x74, then 0x00, then the register address.
- R2: The second frame of a write is 24 bits, sent most significant bit first: 0x76, then bits 15:8 of the value, then bits 7:0 of the value. The value is captured with the start strobe.
- R3: Each write produces exactly two chip-select low intervals, and each interval contains exactly 24 rising serial-clock edges.
- R4: SPI mode 3 is used. The serial clock is high whenever chip select is high. MOSI changes only together with a falling serial-clock edge and stays stable for the whole time the serial clock is high.
- R5: Each serial-clock half period lasts HALF_CYC system clock cycles, so consecutive rising edges within a frame are 2*HALF_CYC cycles apart. The default HALF_CYC of 7 keeps the serial clock below 20 MHz at a 250 MHz system clock.
- R6: Between the two frames, chip select stays high for exactly 2*HALF_CYC cycles, which is one full serial-clock period.
- R7: A start sampled while idle sets busy from the next cycle on. Exactly 100*HALF_CYC cycles after that start edge, done is high for a single cycle, and busy is low in that same cycle.
- R8: A start strobe that arrives while busy is ignored. The running write keeps its frames, no extra frame is sent, and no extra done pulse is given.
- R9: While reset is applied, chip select is high, the serial clock is high, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a register write |
| reg_addr_i | input | 8 | Register address, sampled with start_i |
| value_i | input | 16 | Value to write, sampled with start_i |
| busy_o | output | 1 | High while a write is in progress |
| done_o | output | 1 | One-cycle pulse when the write has completed |
| spi_sck_o | output | 1 | Serial clock, idles high |
| spi_mosi_o | output | 1 | Serial data to the panel |
| spi_cs_n_o | output | 1 | Active-low chip select |

## Verification
Busy is due one cycle after the start edge. Done is due exactly 100*HALF_CYC cycles after that edge. The bench records the cycle count at the negative edge that follows the start edge and checks the done cycle against that count, with no tolerance. It also checks that done has fallen one cycle later. Serial behaviour is observed at every negative edge of the system clock: each 0-to-1 change of the serial clock inside a chip-select interval is decoded as one received bit. The spacing between these edges must be 2*HALF_CYC cycles, and the high time of chip select between the two frames must be 2*HALF_CYC cycles. Both spacings are measured in cycles from the same counter.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;

  localparam int unsigned FRAME_BITS = 24;
  localparam logic [7:0]  SEL_INDEX  = 8'h74;
  localparam logic [7:0]  SEL_DATA   = 8'h76;
  localparam int unsigned HALVES_PER_WRITE = 2 * (1 + 2 * FRAME_BITS) + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } seq_state_t;

endpackage

// File: rtl/panel_spi_tick.sv
module panel_spi_tick #(
  parameter int unsigned HALF_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    if (!run_i)      cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R5

  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_i) |-> cnt_q == '0); // R5

endmodule

// File: rtl/panel_spi_shifter.sv
module panel_spi_shifter #(
  parameter int unsigned NBITS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NBITS-1:0] word_i,
  input  logic             shift_i,
  output logic             mosi_o,
  output logic             last_o
);

  localparam int unsigned BW = $clog2(NBITS);
  localparam logic [BW-1:0] TOP = BW'(NBITS - 1);

  logic [NBITS-1:0] sr_q, sr_d;
  logic [BW-1:0]    bit_q, bit_d;

  assign mosi_o = sr_q[NBITS-1];
  assign last_o = (bit_q == TOP);

  always_comb begin
    sr_d  = sr_q;
    bit_d = bit_q;
    if (load_i) begin
      sr_d  = word_i;
      bit_d = '0;
    end else if (shift_i) begin
      sr_d  = {sr_q[NBITS-2:0], 1'b0};
      bit_d = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      bit_q <= '0;
    end else begin
      sr_q  <= sr_d;
      bit_q <= bit_d;
    end
  end

  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= TOP); // R3

  AST_NO_SHIFT_PAST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |-> !last_o); // R3

endmodule

// File: rtl/panel_spi_seq.sv
module panel_spi_seq
  import panel_spi_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [7:0]            reg_addr_i,
  input  logic [15:0]           value_i,
  input  logic                  tick_i,
  input  logic                  last_i,
  output logic                  run_o,
  output logic                  load_o,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  shift_o,
  output logic                  sck_o,
  output logic                  cs_n_o,
  output logic                  busy_o,
  output logic                  done_o
);

  seq_state_t  state_q, state_d;
  logic        sck_q, sck_d;
  logic        cs_n_q, cs_n_d;
  logic        second_q, second_d;
  logic        gap_q, gap_d;
  logic        done_q, done_d;
  logic [15:0] val_q, val_d;

  always_comb begin
    state_d  = state_q;
    sck_d    = sck_q;
    cs_n_d   = cs_n_q;
    second_d = second_q;
    gap_d    = gap_q;
    val_d    = val_q;
    done_d   = 1'b0;
    load_o   = 1'b0;
    shift_o  = 1'b0;
    word_o   = {SEL_INDEX, 8'h00, reg_addr_i};
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_LEAD;
          cs_n_d   = 1'b0;
          sck_d    = 1'b1;
          second_d = 1'b0;
          val_d    = value_i;
          load_o   = 1'b1;
        end
      end
      ST_LEAD: begin
        if (tick_i) begin
          sck_d   = 1'b0;
          state_d = ST_LOW;
        end
      end
      ST_LOW: begin
        if (tick_i) begin
          sck_d   = 1'b1;
          state_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tick_i) begin
          if (last_i) begin
            cs_n_d = 1'b1;
            if (!second_q) begin
              state_d = ST_GAP;
              gap_d   = 1'b0;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            shift_o = 1'b1;
            sck_d   = 1'b0;
            state_d = ST_LOW;
          end
        end
      end
      ST_GAP: begin
        word_o = {SEL_DATA, val_q};
        if (tick_i) begin
          if (!gap_q) begin
            gap_d = 1'b1;
          end else begin
            state_d  = ST_LEAD;
            cs_n_d   = 1'b0;
            second_d = 1'b1;
            load_o   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sck_q    <= 1'b1;
      cs_n_q   <= 1'b1;
      second_q <= 1'b0;
      gap_q    <= 1'b0;
      done_q   <= 1'b0;
      val_q    <= '0;
    end else begin
      state_q  <= state_d;
      sck_q    <= sck_d;
      cs_n_q   <= cs_n_d;
      second_q <= second_d;
      gap_q    <= gap_d;
      done_q   <= done_d;
      val_q    <= val_d;
    end
  end

  assign run_o  = (state_q != ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);
  assign sck_o  = sck_q;
  assign cs_n_o = cs_n_q;
  assign done_o = done_q;

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sck_q); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_o && $past(busy_o) && $rose(cs_n_q))); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (state_q == ST_LOW)) |=> (busy_o && !cs_n_q && $stable(second_q))); // R8

endmodule

// File: rtl/panel_spi_writer.sv
module panel_spi_writer
  import panel_spi_pkg::*;
#(
  parameter int unsigned HALF_CYC = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [15:0] value_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        spi_sck_o,
  output logic        spi_mosi_o,
  output logic        spi_cs_n_o
);

  logic                  run;
  logic                  tick;
  logic                  load;
  logic                  shift;
  logic                  last;
  logic [FRAME_BITS-1:0] word;

  panel_spi_tick #(.HALF_CYC(HALF_CYC)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .tick_o (tick)
  );

  panel_spi_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .reg_addr_i (reg_addr_i),
    .value_i    (value_i),
    .tick_i     (tick),
    .last_i     (last),
    .run_o      (run),
    .load_o     (load),
    .word_o     (word),
    .shift_o    (shift),
    .sck_o      (spi_sck_o),
    .cs_n_o     (spi_cs_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  panel_spi_shifter #(.NBITS(FRAME_BITS)) shift_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .word_i  (word),
    .shift_i (shift),
    .mosi_o  (spi_mosi_o),
    .last_o  (last)
  );

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck_o && $past(spi_sck_o) && !spi_cs_n_o && !$fell(spi_cs_n_o)) |-> $stable(spi_mosi_o)); // R4

  AST_SCK_FALL_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_sck_o) |-> !spi_cs_n_o); // R3

endmodule

// File: tb/panel_spi_writer_tb_top.sv
`timescale 1ns/1ps
module panel_spi_writer_tb_top;

  localparam int H = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  reg_addr_i;
  logic [15:0] value_i;
  logic        busy_o, done_o, spi_sck_o, spi_mosi_o, spi_cs_n_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  panel_spi_writer #(.HALF_CYC(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_addr_i(reg_addr_i),
    .value_i(value_i), .busy_o(busy_o), .done_o(done_o), .spi_sck_o(spi_sck_o),
    .spi_mosi_o(spi_mosi_o), .spi_cs_n_o(spi_cs_n_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_index(input logic [7:0] a);
    return {8'h74, 8'h00, a};
  endfunction

  function automatic logic [23:0] exp_data(input logic [15:0] v);
    return {8'h76, v[15:8], v[7:0]};
  endfunction

  // serial monitor, sampled at the negative clock edge
  logic [23:0] mon_data [0:7];
  int          mon_bits [0:7];
  int          mon_n = 0;
  int          last_gap = -1;
  logic        p_sck = 1'b1, p_cs = 1'b1, held = 1'b0;
  logic [23:0] cur_sr = '0;
  int          cur_bits = 0, last_rise = 0, cs_rise = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n_o) chk(spi_sck_o == 1'b1, "R4 sck idle", spi_sck_o, 1);
      if (p_cs && !spi_cs_n_o) begin
        cur_bits = 0;
        cur_sr   = '0;
        if (mon_n == 1) last_gap = cyc - cs_rise;
      end
      if (!spi_cs_n_o && spi_sck_o && !p_sck) begin
        if (cur_bits > 0) chk((cyc - last_rise) == 2*H, "R5 sck period", cyc - last_rise, 2*H);
        last_rise = cyc;
        cur_sr    = {cur_sr[22:0], spi_mosi_o};
        held      = spi_mosi_o;
        cur_bits++;
      end else if (!spi_cs_n_o && spi_sck_o && p_sck && cur_bits > 0) begin
        chk(spi_mosi_o == held, "R4 mosi stable", spi_mosi_o, held);
      end
      if (!p_cs && spi_cs_n_o) begin
        if (mon_n < 8) begin
          mon_data[mon_n] = cur_sr;
          mon_bits[mon_n] = cur_bits;
        end
        mon_n++;
        cs_rise = cyc;
      end
    end
    p_sck = spi_sck_o;
    p_cs  = spi_cs_n_o;
  end

  task automatic do_write(input logic [7:0] a, input logic [15:0] v, input bit poke);
    int c0, dc;
    bit seen;
    mon_n    = 0;
    last_gap = -1;
    start_i    = 1'b1;
    reg_addr_i = a;
    value_i    = v;
    @(negedge clk);
    c0 = cyc;
    start_i    = 1'b0;
    reg_addr_i = ~a;
    value_i    = ~v;
    chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    if (poke) begin
      repeat (50*H) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    seen = 0;
    dc   = 0;
    for (int i = 0; i < 200*H && !seen; i++) begin
      if (done_o) begin seen = 1; dc = cyc; end
      else @(negedge clk);
    end
    chk(seen, "R7 done seen", seen, 1);
    chk((dc - c0) == 100*H, "R7 done latency", dc - c0, 100*H);
    chk(busy_o == 1'b0, "R7 busy low at done", busy_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done single cycle", done_o, 0);
    chk(mon_n == 2, "R3 frame count", mon_n, 2);
    chk(mon_bits[0] == 24, "R3 index frame bits", mon_bits[0], 24);
    chk(mon_bits[1] == 24, "R3 data frame bits", mon_bits[1], 24);
    chk(mon_data[0] == exp_index(a), "R1 index frame", mon_data[0], exp_index(a));
    chk(mon_data[1] == exp_data(v), "R2 data frame", mon_data[1], exp_data(v));
    chk(last_gap == 2*H, "R6 cs gap", last_gap, 2*H);
    if (poke) begin
      seen = 0;
      for (int i = 0; i < 120*H; i++) begin
        if (done_o || busy_o) seen = 1;
        @(negedge clk);
      end
      chk(!seen, "R8 no second transaction", seen, 0);
      chk(mon_n == 2, "R8 no extra frames", mon_n, 2);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n      = 1'b0;
    start_i    = 1'b0;
    reg_addr_i = '0;
    value_i    = '0;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk(spi_cs_n_o == 1'b1, "R9 reset cs", spi_cs_n_o, 1);
    chk(spi_sck_o == 1'b1, "R9 reset sck", spi_sck_o, 1);
    chk(busy_o == 1'b0, "R9 reset busy", busy_o, 0);
    chk(done_o == 1'b0, "R9 reset done", done_o, 0);
    start_i = 1'b0;
    rst_n   = 1'b1;
    repeat (2) @(negedge clk);

    do_write(8'h11, 16'h0000, 0);
    do_write(8'h11, 16'h0001, 0);
    do_write(8'h01, 16'h2AEF, 0);
    do_write(8'hFF, 16'hFFFF, 0);
    do_write(8'h00, 16'h0000, 0);
    do_write(8'hA5, 16'h5A3C, 1);
    for (int k = 0; k < 16; k++) begin
      do_write(8'($urandom), 16'($urandom), ($urandom % 5) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule